// File: doc/BRIEF.md
# Master-Clock to Frame-Clock Ratio Monitor

This block watches two free-running audio clocks, a fast master clock and a frame (left/right) clock, and decides whether their relationship is one that the downstream converter path can use. It runs entirely on a faster reference clock. Both audio clocks are sampled and synchronised, and rising edges are extracted from them. The block counts master-clock rising edges over each frame-clock period and maps the count to one of three nominal ratios (256, 384, 512), or to "invalid".

A ratio is only reported as usable after the same supported ratio has been measured in two consecutive frame periods. Three events withdraw the usable flag and raise a single-cycle fault strobe: a switch to a different supported ratio, an unsupported count, and the loss of either clock. A downstream mute controller uses the flag to gate audio and the strobe to start an immediate mute.

Top module: `clk_ratio_monitor`

## Requirements
- R1: A measurement is the number of master-clock rising edges seen between two consecutive frame-clock rising edges, and it is taken at each frame-clock rising edge.
- R2: A measurement within plus or minus TOLERANCE (default 2) of 256, 384 or 512 is classified as code 1, 2 or 3 on `ratio_o`. Any other measurement is code 0 (invalid), so 514 counts as 512 and 515 is invalid.
- R3: `valid_o` rises only after two consecutive measurements give the same supported code. The first frame-clock rising edge after reset or after a clock loss only starts a measurement.
- R4: While `valid_o` is high, a measurement with the same code keeps `valid_o` high and `ratio_o` unchanged, and raises no fault.
- R5: While `valid_o` is high, a measurement with a different supported code drops `valid_o` and raises a fault. The new code then needs one more matching measurement to become valid.
- R6: While `valid_o` is high, an invalid measurement drops `valid_o` and raises a fault.
- R7: If 1024 master-clock rising edges arrive without a frame-clock rising edge, the frame clock is declared lost. This drops `valid_o`, raises a fault if it was high, and restarts qualification.
- R8: If no master-clock rising edge arrives for MCLK_TIMEOUT (default 64) reference-clock cycles, the master clock is declared lost. This drops `valid_o`, raises a fault if it was high, and restarts qualification.
- R9: `fault_o` is high for exactly one cycle, in the first cycle that `valid_o` is low after being high. An invalid measurement while `valid_o` is already low raises no fault.
- R10: After reset, `valid_o`, `ratio_o` and `fault_o` are all 0.
- R11: `ratio_o` is 0 whenever `valid_o` is 0, and nonzero whenever `valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock, faster than twice the master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mclk_i | input | 1 | Master audio clock, sampled as data |
| lrclk_i | input | 1 | Frame (left/right) clock, sampled as data |
| ratio_o | output | 2 | Qualified ratio code: 0 invalid, 1 = 256, 2 = 384, 3 = 512 |
| valid_o | output | 1 | Clock relationship qualified and usable |
| fault_o | output | 1 | One-cycle strobe when a qualified relationship is lost |

## Verification
The hardest situation to reach is a clock loss that lands in the middle of a frame. In that case the partial count left behind must not be taken as a measurement, and the next frame edge must only restart counting. The stimulus reaches it in two ways: it keeps the master clock running with the frame clock frozen low for 1100 master cycles, and it freezes the master clock for 200 reference cycles between frames. After each loss it checks that two further full frames are needed before the flag returns. The tolerance edges (514 accepted, 515 rejected) and an alternating 384/512 pattern that never qualifies exercise the classification and the two-in-a-row rule.

// File: rtl/mrm_pkg.sv
package mrm_pkg;

   typedef enum logic [1:0] {
      RC_INVALID = 2'd0,
      RC_LOW     = 2'd1,
      RC_MID     = 2'd2,
      RC_HIGH    = 2'd3
   } ratio_code_e;

endpackage

// File: rtl/mrm_edge_sync.sv
module mrm_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("mrm_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], async_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/mrm_period_counter.sv
module mrm_period_counter #(
   parameter int LR_TIMEOUT = 1024,
   parameter int CNT_W      = $clog2(LR_TIMEOUT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mclk_rise_i,
   input  logic             lr_rise_i,
   output logic             meas_stb_o,
   output logic [CNT_W-1:0] meas_cnt_o,
   output logic             lr_loss_o
);

   localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(LR_TIMEOUT);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LR_TIMEOUT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (lr_rise_i) begin
         cnt_q <= mclk_rise_i ? CNT_W'(1) : '0;
      end else if (mclk_rise_i && cnt_q != CNT_SAT) begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assign meas_stb_o = lr_rise_i;
   assign meas_cnt_o = cnt_q;
   assign lr_loss_o  = mclk_rise_i && !lr_rise_i && (cnt_q == CNT_LAST);

   p_count_bounded_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_SAT);

   p_lr_loss_single_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lr_loss_o |=> !lr_loss_o);

endmodule

// File: rtl/mrm_mclk_watchdog.sv
module mrm_mclk_watchdog #(
   parameter int MCLK_TIMEOUT = 64,
   parameter int WD_W         = $clog2(MCLK_TIMEOUT + 1)
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic mclk_rise_i,
   output logic loss_stb_o,
   output logic absent_o
);

   localparam logic [WD_W-1:0] WD_SAT  = WD_W'(MCLK_TIMEOUT);
   localparam logic [WD_W-1:0] WD_LAST = WD_W'(MCLK_TIMEOUT - 1);

   logic [WD_W-1:0] idle_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         idle_q <= '0;
      end else if (mclk_rise_i) begin
         idle_q <= '0;
      end else if (idle_q != WD_SAT) begin
         idle_q <= idle_q + WD_W'(1);
      end
   end

   assign loss_stb_o = !mclk_rise_i && (idle_q == WD_LAST);
   assign absent_o   = !mclk_rise_i && (idle_q == WD_SAT);

   p_idle_bounded_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      idle_q <= WD_SAT);

   p_loss_then_absent_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      loss_stb_o |=> (absent_o || mclk_rise_i));

endmodule

// File: rtl/mrm_qualifier.sv
module mrm_qualifier
   import mrm_pkg::*;
#(
   parameter int NOM_LOW   = 256,
   parameter int NOM_MID   = 384,
   parameter int NOM_HIGH  = 512,
   parameter int TOLERANCE = 2,
   parameter int CNT_W     = 11
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             meas_stb_i,
   input  logic [CNT_W-1:0] meas_cnt_i,
   input  logic             lr_loss_i,
   input  logic             mclk_loss_i,
   input  logic             mclk_absent_i,
   output ratio_code_e      ratio_o,
   output logic             valid_o,
   output logic             fault_o
);

   localparam int NUM_RATIOS = 3;
   localparam int NOMS [NUM_RATIOS] = '{NOM_LOW, NOM_MID, NOM_HIGH};

   function automatic ratio_code_e classify(input logic [CNT_W-1:0] c);
      ratio_code_e code;
      code = RC_INVALID;
      for (int k = 0; k < NUM_RATIOS; k++) begin
         if (c >= CNT_W'(NOMS[k] - TOLERANCE) && c <= CNT_W'(NOMS[k] + TOLERANCE)) begin
            code = ratio_code_e'(2'(k + 1));
         end
      end
      return code;
   endfunction

   ratio_code_e meas_code;
   ratio_code_e cand_q;
   ratio_code_e ratio_q;
   logic        armed_q;
   logic        valid_q;
   logic        fault_q;

   assign meas_code = classify(meas_cnt_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         cand_q  <= RC_INVALID;
         ratio_q <= RC_INVALID;
         valid_q <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         fault_q <= 1'b0;
         if (lr_loss_i || mclk_loss_i) begin
            fault_q <= valid_q;
            valid_q <= 1'b0;
            ratio_q <= RC_INVALID;
            cand_q  <= RC_INVALID;
            armed_q <= 1'b0;
         end else if (meas_stb_i) begin
            if (!armed_q || mclk_absent_i) begin
               armed_q <= !mclk_absent_i;
            end else if (meas_code == RC_INVALID) begin
               fault_q <= valid_q;
               valid_q <= 1'b0;
               ratio_q <= RC_INVALID;
               cand_q  <= RC_INVALID;
            end else if (valid_q) begin
               if (meas_code != ratio_q) begin
                  fault_q <= 1'b1;
                  valid_q <= 1'b0;
                  ratio_q <= RC_INVALID;
                  cand_q  <= meas_code;
               end
            end else if (meas_code == cand_q) begin
               valid_q <= 1'b1;
               ratio_q <= meas_code;
            end else begin
               cand_q <= meas_code;
            end
         end
      end
   end

   assign ratio_o = ratio_q;
   assign valid_o = valid_q;
   assign fault_o = fault_q;

   p_fault_only_on_drop_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_q |-> (!valid_q && $past(valid_q)));

   p_drop_raises_fault_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!valid_q && $past(valid_q)) |-> fault_q);

   p_zero_when_invalid_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_q |-> (ratio_q == RC_INVALID));

   p_code_when_valid_r11 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_q |-> (ratio_q != RC_INVALID));

   p_hold_while_valid_r4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_q && $past(valid_q)) |-> $stable(ratio_q));

   p_rise_needs_measure_r3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(valid_q) |-> $past(meas_stb_i));

   p_lr_loss_clears_r7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      lr_loss_i |=> !valid_q);

   p_mclk_loss_clears_r8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      mclk_loss_i |=> !valid_q);

endmodule

// File: rtl/clk_ratio_monitor.sv
module clk_ratio_monitor #(
   parameter int SYNC_STAGES  = 2,
   parameter int NOM_LOW      = 256,
   parameter int NOM_MID      = 384,
   parameter int NOM_HIGH     = 512,
   parameter int TOLERANCE    = 2,
   parameter int LR_TIMEOUT   = 1024,
   parameter int MCLK_TIMEOUT = 64
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       mclk_i,
   input  logic       lrclk_i,
   output logic [1:0] ratio_o,
   output logic       valid_o,
   output logic       fault_o
);

   import mrm_pkg::*;

   localparam int CNT_W   = $clog2(LR_TIMEOUT + 1);
   localparam int N_CLKS  = 2;
   localparam int IDX_MCK = 0;
   localparam int IDX_LRC = 1;

   if (TOLERANCE < 0 || NOM_LOW <= TOLERANCE) begin : g_bad_tol
      $error("clk_ratio_monitor: tolerance out of range");
   end
   if (NOM_LOW + TOLERANCE >= NOM_MID - TOLERANCE ||
       NOM_MID + TOLERANCE >= NOM_HIGH - TOLERANCE) begin : g_bad_order
      $error("clk_ratio_monitor: ratio windows overlap or are unordered");
   end
   if (NOM_HIGH + TOLERANCE >= LR_TIMEOUT) begin : g_bad_lr_to
      $error("clk_ratio_monitor: frame timeout too short for largest ratio");
   end
   if (MCLK_TIMEOUT < 4) begin : g_bad_mck_to
      $error("clk_ratio_monitor: master-clock timeout too short");
   end

   logic [N_CLKS-1:0] raw_clk;
   logic [N_CLKS-1:0] clk_rise;

   assign raw_clk[IDX_MCK] = mclk_i;
   assign raw_clk[IDX_LRC] = lrclk_i;

   for (genvar g = 0; g < N_CLKS; g++) begin : g_sync
      mrm_edge_sync #(.STAGES(SYNC_STAGES)) i_sync (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .async_i(raw_clk[g]),
         .rise_o (clk_rise[g])
      );
   end

   logic             meas_stb;
   logic [CNT_W-1:0] meas_cnt;
   logic             lr_loss;
   logic             mclk_loss;
   logic             mclk_absent;
   ratio_code_e      ratio_code;

   mrm_period_counter #(.LR_TIMEOUT(LR_TIMEOUT), .CNT_W(CNT_W)) i_counter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mclk_rise_i(clk_rise[IDX_MCK]),
      .lr_rise_i  (clk_rise[IDX_LRC]),
      .meas_stb_o (meas_stb),
      .meas_cnt_o (meas_cnt),
      .lr_loss_o  (lr_loss)
   );

   mrm_mclk_watchdog #(.MCLK_TIMEOUT(MCLK_TIMEOUT)) i_watchdog (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mclk_rise_i(clk_rise[IDX_MCK]),
      .loss_stb_o (mclk_loss),
      .absent_o   (mclk_absent)
   );

   mrm_qualifier #(
      .NOM_LOW  (NOM_LOW),
      .NOM_MID  (NOM_MID),
      .NOM_HIGH (NOM_HIGH),
      .TOLERANCE(TOLERANCE),
      .CNT_W    (CNT_W)
   ) i_qualifier (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .meas_stb_i   (meas_stb),
      .meas_cnt_i   (meas_cnt),
      .lr_loss_i    (lr_loss),
      .mclk_loss_i  (mclk_loss),
      .mclk_absent_i(mclk_absent),
      .ratio_o      (ratio_code),
      .valid_o      (valid_o),
      .fault_o      (fault_o)
   );

   assign ratio_o = ratio_code;

   p_fault_single_r9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_o |=> !fault_o);

endmodule

// File: tb/test_clk_ratio_monitor.sv
module test_clk_ratio_monitor;

   localparam int TOL     = 2;
   localparam int LR_TO   = 1024;
   localparam int MCK_TO  = 64;
   localparam int SETTLE  = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mclk = 1'b0;
   logic       lrclk = 1'b0;
   logic [1:0] ratio;
   logic       valid;
   logic       fault;

   always #10 clk = ~clk;

   clk_ratio_monitor i_clk_ratio_monitor (
      .clk_i  (clk),
      .rst_ni (rst_n),
      .mclk_i (mclk),
      .lrclk_i(lrclk),
      .ratio_o(ratio),
      .valid_o(valid),
      .fault_o(fault)
   );

   int errors = 0;
   int checks = 0;
   bit done = 0;
   bit live = 0;
   int settle = 0;
   string cur_req = "R10";

   // reference model state
   bit m_armed = 0;
   int m_cand = 0;
   bit m_valid = 0;
   int m_ratio = 0;
   int m_exp_faults = 0;
   int obs_faults = 0;
   int rises_since_lr = 0;

   function automatic int ref_class(int m);
      int noms[3] = '{256, 384, 512};
      for (int k = 0; k < 3; k++) begin
         int d = m - noms[k];
         if (d < 0) d = -d;
         if (d <= TOL) return k + 1;
      end
      return 0;
   endfunction

   task automatic check(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_drop();
      if (m_valid) m_exp_faults++;
      m_valid = 0; m_ratio = 0; m_cand = 0;
   endtask

   task automatic model_loss();
      model_drop();
      m_armed = 0;
   endtask

   task automatic model_frame_rise();
      int code;
      if (!m_armed) begin
         m_armed = 1;
      end else begin
         code = ref_class(rises_since_lr);
         if (code == 0) model_drop();
         else if (m_valid) begin
            if (code != m_ratio) begin
               m_exp_faults++; m_valid = 0; m_ratio = 0; m_cand = code;
            end
         end else if (code == m_cand) begin
            m_valid = 1; m_ratio = code;
         end else m_cand = code;
      end
      rises_since_lr = 0;
      settle = SETTLE;
   endtask

   task automatic model_mclk_rise();
      rises_since_lr++;
      if (rises_since_lr == LR_TO) begin
         model_loss();
         settle = SETTLE;
      end
   endtask

   task automatic one_mclk();
      mclk = 1'b1;
      model_mclk_rise();
      @(negedge clk); @(negedge clk);
      mclk = 1'b0;
      @(negedge clk); @(negedge clk);
   endtask

   task automatic run_frames(int len, int n);
      for (int f = 0; f < n; f++) begin
         for (int i = 0; i < len; i++) begin
            if (i == 0) begin
               lrclk = 1'b1;
               model_frame_rise();
            end
            if (i == len / 2) lrclk = 1'b0;
            one_mclk();
         end
      end
   endtask

   task automatic mclk_only(int n);
      for (int i = 0; i < n; i++) one_mclk();
   endtask

   task automatic mclk_gap(int n);
      mclk = 1'b0;
      model_loss();
      settle = MCK_TO + SETTLE + 8;
      repeat (n) @(negedge clk);
   endtask

   // every-clock comparison against the model
   always @(negedge clk) begin
      if (live) begin
         if (fault) obs_faults++;
         if (settle > 0) settle--;
         else begin
            checks++;
            if (valid !== m_valid || ratio !== 2'(m_ratio) || obs_faults != m_exp_faults) begin
               errors++;
               $display("FAIL %s: actual valid=%0b ratio=%0d faults=%0d expected valid=%0b ratio=%0d faults=%0d at %0t",
                        cur_req, valid, ratio, obs_faults, m_valid, m_ratio, m_exp_faults, $time);
            end
         end
      end
   end

   initial begin
      int f0;
      repeat (4) @(negedge clk);
      // R10: reset state
      check(valid === 1'b0, "R10 valid after reset", int'(valid), 0);
      check(ratio === 2'd0, "R10 ratio after reset", int'(ratio), 0);
      check(fault === 1'b0, "R10 fault after reset", int'(fault), 0);
      rst_n = 1'b1;
      @(negedge clk);
      live = 1;

      // R3: two matching measurements needed; R1 counts per frame
      cur_req = "R3";
      run_frames(256, 2);
      check(valid === 1'b0, "R3 not valid after one measurement", int'(valid), 0);
      run_frames(256, 1);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1 && ratio === 2'd1, "R1 R3 qualified at 256", int'(ratio), 1);

      // R2 R4: within tolerance keeps ratio, no fault
      cur_req = "R4";
      f0 = obs_faults;
      run_frames(258, 2);
      run_frames(254, 2);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1 && ratio === 2'd1, "R2 R4 tolerance holds code 1", int'(ratio), 1);
      check(obs_faults == f0, "R4 no fault inside tolerance", obs_faults - f0, 0);

      // R5: switch between supported ratios
      cur_req = "R5";
      f0 = obs_faults;
      run_frames(384, 3);
      repeat (SETTLE) @(negedge clk);
      check(obs_faults - f0 == 1, "R5 fault on switch to 384", obs_faults - f0, 1);
      check(valid === 1'b1 && ratio === 2'd2, "R5 requalified at 384", int'(ratio), 2);
      run_frames(512, 3);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1 && ratio === 2'd3, "R5 requalified at 512", int'(ratio), 3);

      // R2 boundary: 514 accepted, 515 rejected (R6)
      cur_req = "R2";
      run_frames(514, 2);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1 && ratio === 2'd3, "R2 514 stays code 3", int'(ratio), 3);
      cur_req = "R6";
      f0 = obs_faults;
      run_frames(515, 2);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b0 && ratio === 2'd0, "R6 515 invalid drops", int'(ratio), 0);
      check(obs_faults - f0 == 1, "R6 fault on invalid count", obs_faults - f0, 1);

      // R9 R11: invalid while already not valid: no fault, code 0
      cur_req = "R9";
      f0 = obs_faults;
      run_frames(515, 1);
      repeat (SETTLE) @(negedge clk);
      check(obs_faults == f0, "R9 no fault while not valid", obs_faults - f0, 0);
      check(ratio === 2'd0, "R11 code 0 while not valid", int'(ratio), 0);
      run_frames(256, 3);

      // R7: frame clock lost
      cur_req = "R7";
      f0 = obs_faults;
      mclk_only(1100);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b0, "R7 frame clock loss drops valid", int'(valid), 0);
      check(obs_faults - f0 == 1, "R7 fault on frame clock loss", obs_faults - f0, 1);
      run_frames(256, 2);
      check(valid === 1'b0, "R7 R3 first edge after loss only arms", int'(valid), 0);
      run_frames(256, 1);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1, "R7 requalified after loss", int'(valid), 1);

      // R8: master clock lost
      cur_req = "R8";
      f0 = obs_faults;
      mclk_gap(200);
      check(valid === 1'b0, "R8 master clock loss drops valid", int'(valid), 0);
      check(obs_faults - f0 == 1, "R8 fault on master clock loss", obs_faults - f0, 1);
      run_frames(256, 3);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b1 && ratio === 2'd1, "R8 requalified after gap", int'(ratio), 1);

      // R3: alternating supported ratios never qualify
      cur_req = "R3";
      run_frames(384, 1);
      run_frames(512, 1);
      run_frames(384, 1);
      run_frames(512, 1);
      repeat (SETTLE) @(negedge clk);
      check(valid === 1'b0, "R3 alternating ratios never valid", int'(valid), 0);

      live = 0;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule